// File: doc/BRIEF.md
# Event-Driven Video Channel Selector

This block watches a stream of decoded timing events. From that stream it picks which of three video sources a downstream analog switch should route to a recorder. Each event arrives as an 8-bit code qualified by a one-cycle valid strobe. The block keeps three window flags. Each flag is raised by one event code and lowered by another.

The source choice depends on which event arrives and on which windows are open at that moment. One window, the main window, gates almost every selection. While the main window is closed, the block holds the third source as a default.

The selection drives a 4-bit binary address with weights 1, 2, 4 and 8. Only the values 0, 1 and 2 are ever produced. A separate indicator output shows whether the main window is open.

Top module: `vidChanSel`

## Requirements
- R1: While reset is asserted and after it is released, with no event yet, all three windows are closed, `muxAddr` is 2 and `mainWinOpen` is 0.
- R2: `muxAddr` is a binary address whose bits 0..3 carry weights 1, 2, 4 and 8. Its value is always 0, 1 or 2, so bits 3:2 are always 0.
- R3: The main window opens on code 0xC1 and closes on 0x42. The second window opens on 0x2A and closes on 0x26. The exclusion window opens on 0x9A and closes on 0x2A. An event's effect appears at the outputs after the clock edge on which `evtValid` is sampled high.
- R4: Code 0x9A or 0x2A arriving while the main window is open selects address 0. With the main window closed, these codes leave the address unchanged.
- R5: Code 0x94 arriving while the main window is open selects address 1. Otherwise it leaves the address unchanged.
- R6: Code 0x25 selects address 2 only while both the main and the second window are open. Otherwise it leaves the address unchanged.
- R7: Code 0x2B selects address 2 unless the exclusion window is open. When the exclusion window is open, the address is left unchanged.
- R8: Whenever the main window is closed, `muxAddr` is 2. The closing event 0x42 sets address 2 on the same edge that closes the window.
- R9: `mainWinOpen` is 1 exactly while the main window is open.
- R10: A selection is decided using the window states held before the event. Window changes made by the same event take effect on the same clock edge. For example, 0x2A with both the main and exclusion windows open selects address 0 and also closes the exclusion window, so a following 0x2B selects address 2.
- R11: A code that matches no rule, or any code presented with `evtValid` low, leaves the address and all windows unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| evtValid | input | 1 | High for one cycle per decoded event |
| evtCode | input | 8 | Decoded event code |
| muxAddr | output | 4 | Video multiplexer address (weights 1, 2, 4, 8) |
| mainWinOpen | output | 1 | High while the main window is open |

## Verification
Only the main window is visible directly, through `mainWinOpen`. A wrong state in the second or exclusion window shows only when a code that depends on it arrives: a 0x25 or 0x2B then moves the address wrongly, or fails to move it, one edge after that event. A wrong channel register shows at `muxAddr` on the cycle after the faulty edge. A missed forced default shows the first time the main window closes. The random event mix therefore favours the eight meaningful codes, so each hidden flag is probed soon after every change.

// File: rtl/vidsel_pkg.sv
package vidsel_pkg;

  // Strobes from the control to the datapath: which channel to load this edge.
  typedef struct packed {
    logic pickCh0;
    logic pickCh1;
    logic pickCh2;
  } chanStrobe_t;

  localparam int unsigned NUM_WIN = 3;
  localparam int unsigned WIN_MAIN = 0;
  localparam int unsigned WIN_SECOND = 1;
  localparam int unsigned WIN_EXCL = 2;

endpackage

// File: rtl/vidselWindow.sv
module vidselWindow #(
  parameter int unsigned EVT_W = 8,
  parameter logic [EVT_W-1:0] OPEN_CODE = '0,
  parameter logic [EVT_W-1:0] CLOSE_CODE = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtValid,
  input  logic [EVT_W-1:0] evtCode,
  output logic             isOpen
);

  logic openHit;
  logic closeHit;

  assign openHit  = evtValid && (evtCode == OPEN_CODE);
  assign closeHit = evtValid && (evtCode == CLOSE_CODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isOpen <= 1'b0;
    end else if (closeHit) begin
      isOpen <= 1'b0;
    end else if (openHit) begin
      isOpen <= 1'b1;
    end
  end

  // R3
  win_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtCode == OPEN_CODE && evtCode != CLOSE_CODE) |=> isOpen);

  // R3
  win_closes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtCode == CLOSE_CODE) |=> !isOpen);

  // R11
  win_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !evtValid |=> $stable(isOpen));

endmodule

// File: rtl/vidselCtrl.sv
module vidselCtrl
  import vidsel_pkg::*;
#(
  parameter int unsigned EVT_W = 8,
  parameter logic [EVT_W-1:0] MAIN_OPEN = 8'hC1,
  parameter logic [EVT_W-1:0] MAIN_CLOSE = 8'h42,
  parameter logic [EVT_W-1:0] SECOND_OPEN = 8'h2A,
  parameter logic [EVT_W-1:0] SECOND_CLOSE = 8'h26,
  parameter logic [EVT_W-1:0] EXCL_OPEN = 8'h9A,
  parameter logic [EVT_W-1:0] EXCL_CLOSE = 8'h2A,
  parameter logic [EVT_W-1:0] PICK0_A = 8'h9A,
  parameter logic [EVT_W-1:0] PICK0_B = 8'h2A,
  parameter logic [EVT_W-1:0] PICK1 = 8'h94,
  parameter logic [EVT_W-1:0] PICK2_PAIR = 8'h25,
  parameter logic [EVT_W-1:0] PICK2_FREE = 8'h2B
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtValid,
  input  logic [EVT_W-1:0] evtCode,
  output chanStrobe_t      strobe,
  output logic             mainOpen
);

  localparam logic [NUM_WIN*EVT_W-1:0] OPEN_PACK  = {EXCL_OPEN, SECOND_OPEN, MAIN_OPEN};
  localparam logic [NUM_WIN*EVT_W-1:0] CLOSE_PACK = {EXCL_CLOSE, SECOND_CLOSE, MAIN_CLOSE};

  logic [NUM_WIN-1:0] winOpen;

  for (genvar k = 0; k < NUM_WIN; k++) begin : gWin
    vidselWindow #(
      .EVT_W     (EVT_W),
      .OPEN_CODE (OPEN_PACK[k*EVT_W +: EVT_W]),
      .CLOSE_CODE(CLOSE_PACK[k*EVT_W +: EVT_W])
    ) uWin (
      .clk     (clk),
      .rstN    (rstN),
      .evtValid(evtValid),
      .evtCode (evtCode),
      .isOpen  (winOpen[k])
    );
  end

  logic winMain;
  logic winSecond;
  logic winExcl;
  logic hitPick0;
  logic hitPick1;
  logic hitPair;
  logic hitFree;
  logic hitMainClose;

  assign winMain   = winOpen[WIN_MAIN];
  assign winSecond = winOpen[WIN_SECOND];
  assign winExcl   = winOpen[WIN_EXCL];

  assign hitPick0     = evtValid && ((evtCode == PICK0_A) || (evtCode == PICK0_B));
  assign hitPick1     = evtValid && (evtCode == PICK1);
  assign hitPair      = evtValid && (evtCode == PICK2_PAIR);
  assign hitFree      = evtValid && (evtCode == PICK2_FREE);
  assign hitMainClose = evtValid && (evtCode == MAIN_CLOSE);

  // Decisions use the windows as registered before this edge.
  always_comb begin
    strobe = '0;
    if (hitMainClose) begin
      strobe.pickCh2 = 1'b1;
    end else if (winMain && hitPick0) begin
      strobe.pickCh0 = 1'b1;
    end else if (winMain && hitPick1) begin
      strobe.pickCh1 = 1'b1;
    end else if (winMain && winSecond && hitPair) begin
      strobe.pickCh2 = 1'b1;
    end else if (!winExcl && hitFree) begin
      strobe.pickCh2 = 1'b1;
    end
  end

  assign mainOpen = winMain;

  // R7
  excl_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winExcl && hitFree) |-> (strobe == '0));

  // R4
  pick_needs_main_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pickCh0 || strobe.pickCh1) |-> winMain);

endmodule

// File: rtl/vidselPath.sv
module vidselPath
  import vidsel_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobe_t       strobe,
  output logic [ADDR_W-1:0] chanAddr
);

  localparam logic [ADDR_W-1:0] CH0 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CH1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] CH2 = ADDR_W'(2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanAddr <= CH2;
    end else if (strobe.pickCh2) begin
      chanAddr <= CH2;
    end else if (strobe.pickCh1) begin
      chanAddr <= CH1;
    end else if (strobe.pickCh0) begin
      chanAddr <= CH0;
    end
  end

  // R2
  one_pick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    chanAddr <= CH2);

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> $stable(chanAddr));

endmodule

// File: rtl/vidChanSel.sv
module vidChanSel
  import vidsel_pkg::*;
#(
  parameter int unsigned EVT_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [EVT_W-1:0]  evtCode,
  output logic [ADDR_W-1:0] muxAddr,
  output logic              mainWinOpen
);

  chanStrobe_t strobe;

  vidselCtrl #(.EVT_W(EVT_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .evtValid(evtValid),
    .evtCode (evtCode),
    .strobe  (strobe),
    .mainOpen(mainWinOpen)
  );

  vidselPath #(.ADDR_W(ADDR_W)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .chanAddr(muxAddr)
  );

  // R8
  closed_default_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mainWinOpen |-> (muxAddr == ADDR_W'(2)));

  // R5
  pick_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mainWinOpen && evtValid && evtCode == EVT_W'(8'h94)) |=> (muxAddr == ADDR_W'(1)));

  // R9
  main_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mainWinOpen) |-> $past(evtValid && evtCode == EVT_W'(8'hC1)));

endmodule

// File: tb/tb_vidChanSel.sv
`timescale 1ns/1ps
module tb_vidChanSel;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evtValid = 1'b0;
  logic [7:0] evtCode = 8'h00;
  logic [3:0] muxAddr;
  logic       mainWinOpen;

  int unsigned nChecks = 0;
  int unsigned nFails = 0;
  int unsigned cycles = 0;
  bit          done = 1'b0;

  // Bench model of the window flags and the channel.
  bit       mA = 0, mB = 0, mC = 0;
  bit [3:0] mCh = 4'd2;

  always #2.5 clk = ~clk;

  vidChanSel dut (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtCode(evtCode),
    .muxAddr(muxAddr), .mainWinOpen(mainWinOpen)
  );

  function automatic bit [3:0] nextChan(bit v, bit [7:0] c, bit a, bit b, bit x, bit [3:0] ch);
    if (!v) return ch;
    if (c == 8'h42) return 4'd2;
    if (a && (c == 8'h9A || c == 8'h2A)) return 4'd0;
    if (a && c == 8'h94) return 4'd1;
    if (a && b && c == 8'h25) return 4'd2;
    if (!x && c == 8'h2B) return 4'd2;
    return ch;
  endfunction

  task automatic modelStep(bit v, bit [7:0] c);
    mCh = nextChan(v, c, mA, mB, mC, mCh);
    if (v) begin
      if (c == 8'hC1) mA = 1;
      if (c == 8'h42) mA = 0;
      if (c == 8'h2A) begin mB = 1; mC = 0; end
      if (c == 8'h26) mB = 0;
      if (c == 8'h9A) mC = 1;
    end
  endtask

  task automatic check(string tag);
    nChecks++;
    if (muxAddr !== mCh || mainWinOpen !== mA) begin
      nFails++;
      $display("FAIL %s: muxAddr=%0d mainWinOpen=%0d expected muxAddr=%0d mainWinOpen=%0d",
               tag, muxAddr, mainWinOpen, mCh, mA);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check at next falling edge.
  task automatic step(bit v, bit [7:0] c, string tag);
    evtValid = v;
    evtCode = c;
    modelStep(v, c);
    @(negedge clk);
    check(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      nFails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    bit [7:0] pool [8] = '{8'hC1, 8'h42, 8'h2A, 8'h26, 8'h9A, 8'h94, 8'h25, 8'h2B};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    step(1, 8'h55, "R11 unmatched code");
    step(1, 8'h25, "R6 pair code with main closed");
    step(1, 8'h9A, "R4 pick0 code with main closed");
    step(1, 8'hC1, "R3 R9 main opens");
    step(1, 8'h94, "R5 pick1 in main");
    step(1, 8'h9A, "R4 pick0 in main");
    step(1, 8'h2B, "R7 free code blocked by exclusion");
    step(1, 8'h2A, "R10 2A selects 0 and closes exclusion");
    step(1, 8'h2B, "R7 R10 free code after exclusion closed");
    step(1, 8'h94, "R5 pick1 again");
    step(1, 8'h25, "R6 pair code with both open");
    step(1, 8'h94, "R2 address weight 1");
    step(1, 8'h26, "R3 second window closes");
    step(1, 8'h25, "R6 pair code with second closed");
    step(0, 8'h9A, "R11 valid low ignored");
    step(1, 8'h42, "R8 main closes forces 2");
    step(1, 8'h94, "R8 pick1 with main closed");
    step(1, 8'h2A, "R4 2A with main closed");

    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom_range(0, 9) != 0);
      bit [7:0] c = ($urandom_range(0, 7) == 0) ? 8'($urandom) : pool[$urandom_range(0, 7)];
      step(v, c, "R2 R3 random mix");
    end

    evtValid = 1'b0;
    rstN = 1'b0;
    mA = 0; mB = 0; mC = 0; mCh = 4'd2;
    @(negedge clk);
    check("R1 reset mid run");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule